// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Frame-Position Status Events

This block takes one asynchronous serial line and turns it into data words. A 16x oversampling enable paces it, and it supports five frame formats: 7 data bits, 7 data bits plus parity, 8 data bits, 8 data bits plus parity, and 9 data bits. A falling edge on the idle line starts a frame. The block checks the start bit at its midpoint. It then samples every later bit at its centre, least significant bit first. The result goes into a single holding buffer that the host empties with a read strobe.

Each status event fires at the sample point inside the frame where its cause becomes known, not at a common end-of-frame moment. A parity mismatch is reported at the centre of the parity bit. The receive interrupt, a framing error and an overrun are reported at the centre of the stop bit. Every event is a one-cycle pulse. The three error events also set sticky flags, and reading the buffer clears them. The block captures the frame format and the parity sense when a frame starts. If the receive enable is dropped during a frame, the block finishes that frame before it goes quiet.

Top module: `uart_rx_timed`

## Requirements
- R1: After a synchronous reset, rx_data, rx_valid, rx_irq, every error pulse and every sticky flag are 0.
- R2: A low level on the line that has gone high again by the start-bit midpoint (8 ticks after the falling edge is detected) causes no reception, no pulse and no change to rx_valid.
- R3: The fmt code selects the frame: 0 is 7 data bits, 1 is 7 data bits with parity, 2 is 8 data bits, 3 is 8 data bits with parity, 4 is 9 data bits. Data bits arrive LSB first and are stored in rx_data zero-extended to 9 bits.
- R4: rx_irq is a one-cycle pulse raised during the stop bit, after its centre sample. rx_data is loaded and rx_valid is set in the same cycle.
- R5: In formats 1 and 3, par_err_pulse is a one-cycle pulse raised during the parity bit, after its centre sample, when the parity does not match. With par_odd=0 the data ones plus the parity bit must be even; with par_odd=1 they must be odd.
- R6: frm_err_pulse is a one-cycle pulse raised during the stop bit, together with rx_irq, when the stop-bit centre sample is low. The word is still stored.
- R7: If rx_valid is still 1 when a frame's stop bit is sampled, ovr_err_pulse fires with rx_irq, the new word is discarded and rx_data keeps the unread word.
- R8: Each error pulse sets its sticky flag. A rd_strobe cycle clears rx_valid and all sticky flags.
- R9: Clearing rx_enable during a frame does not cut it short: the frame completes and is stored. While rx_enable is 0 and the receiver is idle, no new frame starts.
- R10: The block captures fmt and par_odd when a frame starts. Changing them during the frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rx_enable | input | 1 | Allows new frames to start |
| fmt | input | 3 | Frame format code (see R3) |
| par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| rd_strobe | input | 1 | Host read of the holding buffer |
| rx_data | output | 9 | Holding buffer contents |
| rx_valid | output | 1 | Holding buffer holds an unread word |
| rx_irq | output | 1 | Word-received pulse |
| par_err_pulse | output | 1 | Parity mismatch pulse |
| frm_err_pulse | output | 1 | Framing error pulse |
| ovr_err_pulse | output | 1 | Overrun pulse |
| par_err_flag | output | 1 | Sticky parity error |
| frm_err_flag | output | 1 | Sticky framing error |
| ovr_err_flag | output | 1 | Sticky overrun |

## Verification
The assertions assume that rd_strobe is a single-cycle request and that reset is held through the first clock edges. They also assume that unused fmt codes are never applied, because those codes fall back to the 8-bit frame. The stimulus raises os_tick on every second cycle, holds each bit for exactly 16 ticks, and applies the read strobe only between frames, never in the cycle a word is stored. Changes to fmt and to rx_enable are made at bit boundaries, so each frame-capture check has a single well-defined outcome.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    FMT_D7  = 3'd0,
    FMT_D7P = 3'd1,
    FMT_D8  = 3'd2,
    FMT_D8P = 3'd3,
    FMT_D9  = 3'd4
  } rx_fmt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  function automatic int fmt_data_bits(logic [2:0] f);
    case (f)
      FMT_D7, FMT_D7P: return 7;
      FMT_D9:          return 9;
      default:         return 8;
    endcase
  endfunction

  function automatic logic fmt_has_par(logic [2:0] f);
    return (f == FMT_D7P) || (f == FMT_D8P);
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b1;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE  = 16,
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                line,
  input  logic                rx_en,
  input  logic [2:0]          fmt,
  input  logic                par_odd,
  output logic                done,
  output logic                frm_bad,
  output logic                par_bad,
  output logic [DATA_MAX-1:0] word
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(DATA_MAX + 1);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OS_RATE - 1);

  rx_state_e           state;
  logic [CNT_W-1:0]    cnt;
  logic [IDX_W-1:0]    idx;
  logic [DATA_MAX-1:0] shreg;
  logic [2:0]          fmt_q;
  logic                odd_q;
  logic                par_acc;
  logic [IDX_W-1:0]    last_idx;

  always_comb last_idx = IDX_W'(fmt_data_bits(fmt_q) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      fmt_q   <= 3'd0;
      odd_q   <= 1'b0;
      par_acc <= 1'b0;
      word    <= '0;
      done    <= 1'b0;
      frm_bad <= 1'b0;
      par_bad <= 1'b0;
    end else begin
      done    <= 1'b0;
      frm_bad <= 1'b0;
      par_bad <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            if (rx_en && !line) begin
              state <= ST_START;
              cnt   <= '0;
              fmt_q <= fmt;
              odd_q <= par_odd;
            end
          end
          ST_START: begin
            if (cnt == MID_CNT) begin
              cnt     <= '0;
              idx     <= '0;
              shreg   <= '0;
              par_acc <= 1'b0;
              state   <= line ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == LAST_CNT) begin
              cnt        <= '0;
              shreg[idx] <= line;
              par_acc    <= par_acc ^ line;
              idx        <= idx + 1'b1;
              if (idx == last_idx)
                state <= fmt_has_par(fmt_q) ? ST_PAR : ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt == LAST_CNT) begin
              cnt     <= '0;
              par_bad <= par_acc ^ line ^ odd_q;
              state   <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == LAST_CNT) begin
              cnt     <= '0;
              done    <= 1'b1;
              frm_bad <= ~line;
              word    <= shreg;
              state   <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R4: completion is a single-cycle event
  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: a parity verdict only exists for formats that carry parity
  assert_par_only_in_par_fmt_R5: assert property (@(posedge clk) disable iff (rst)
    par_bad |-> fmt_has_par(fmt_q));

  // R9: an idle, disabled receiver stays idle
  assert_idle_when_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !rx_en) |=> state == ST_IDLE);

  // R10: captured format is frozen while a frame is in progress
  assert_fmt_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && $past(state) == ST_DATA) |-> $stable(fmt_q));

endmodule

// File: rtl/rx_holdbuf.sv
module rx_holdbuf #(
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                done,
  input  logic                frm_bad,
  input  logic                par_bad,
  input  logic [DATA_MAX-1:0] word,
  input  logic                rd,
  output logic [DATA_MAX-1:0] data,
  output logic                valid,
  output logic                irq,
  output logic                par_p,
  output logic                frm_p,
  output logic                ovr_p,
  output logic                par_f,
  output logic                frm_f,
  output logic                ovr_f
);
  logic full_blocks;
  logic set_frm;
  logic set_ovr;

  always_comb begin
    full_blocks = valid && !rd;
    set_frm     = done && frm_bad;
    set_ovr     = done && full_blocks;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      valid <= 1'b0;
      irq   <= 1'b0;
      par_p <= 1'b0;
      frm_p <= 1'b0;
      ovr_p <= 1'b0;
      par_f <= 1'b0;
      frm_f <= 1'b0;
      ovr_f <= 1'b0;
    end else begin
      irq   <= done;
      par_p <= par_bad;
      frm_p <= set_frm;
      ovr_p <= set_ovr;
      if (rd) valid <= 1'b0;
      if (done && !full_blocks) begin
        data  <= word;
        valid <= 1'b1;
      end
      if (rd) begin
        par_f <= 1'b0;
        frm_f <= 1'b0;
        ovr_f <= 1'b0;
      end
      if (par_bad) par_f <= 1'b1;
      if (set_frm) frm_f <= 1'b1;
      if (set_ovr) ovr_f <= 1'b1;
    end
  end

  // R4: a word-received pulse always leaves a word in the buffer
  assert_irq_has_word_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> valid);

  // R7: an overrun is only reported alongside a completed frame
  assert_ovr_with_irq_R7: assert property (@(posedge clk) disable iff (rst)
    ovr_p |-> irq);

  // R7: an overrun leaves the unread word untouched
  assert_ovr_keeps_data_R7: assert property (@(posedge clk) disable iff (rst)
    ovr_p |-> $stable(data));

  // R8: a read with no new error clears every sticky flag
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (rd && !par_bad && !set_frm) |=> (!par_f && !frm_f && !ovr_f && !valid));

endmodule

// File: rtl/uart_rx_timed.sv
module uart_rx_timed
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int DATA_MAX    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                os_tick,
  input  logic                rxd,
  input  logic                rx_enable,
  input  logic [2:0]          fmt,
  input  logic                par_odd,
  input  logic                rd_strobe,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_valid,
  output logic                rx_irq,
  output logic                par_err_pulse,
  output logic                frm_err_pulse,
  output logic                ovr_err_pulse,
  output logic                par_err_flag,
  output logic                frm_err_flag,
  output logic                ovr_err_flag
);
  logic                line_s;
  logic                f_done;
  logic                f_frm;
  logic                f_par;
  logic [DATA_MAX-1:0] f_word;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (rxd),
    .d_out (line_s)
  );

  rx_frame_fsm #(.OS_RATE(OS_RATE), .DATA_MAX(DATA_MAX)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .tick    (os_tick),
    .line    (line_s),
    .rx_en   (rx_enable),
    .fmt     (fmt),
    .par_odd (par_odd),
    .done    (f_done),
    .frm_bad (f_frm),
    .par_bad (f_par),
    .word    (f_word)
  );

  rx_holdbuf #(.DATA_MAX(DATA_MAX)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .done    (f_done),
    .frm_bad (f_frm),
    .par_bad (f_par),
    .word    (f_word),
    .rd      (rd_strobe),
    .data    (rx_data),
    .valid   (rx_valid),
    .irq     (rx_irq),
    .par_p   (par_err_pulse),
    .frm_p   (frm_err_pulse),
    .ovr_p   (ovr_err_pulse),
    .par_f   (par_err_flag),
    .frm_f   (frm_err_flag),
    .ovr_f   (ovr_err_flag)
  );

  // R5/R4: parity is judged before the stop bit, never in the same cycle
  assert_par_before_stop_R5: assert property (@(posedge clk) disable iff (rst)
    par_err_pulse |-> !rx_irq);

  // R6: a framing error is reported only together with the word event
  assert_frm_with_irq_R6: assert property (@(posedge clk) disable iff (rst)
    frm_err_pulse |-> rx_irq);

endmodule

// File: tb/test_uart_rx_timed.sv
module test_uart_rx_timed;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick;
  logic       rxd = 1'b1;
  logic       rx_enable = 1'b1;
  logic [2:0] fmt = 3'd2;
  logic       par_odd = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [8:0] rx_data;
  logic       rx_valid, rx_irq, par_err_pulse, frm_err_pulse, ovr_err_pulse;
  logic       par_err_flag, frm_err_flag, ovr_err_flag;

  int errors = 0;
  int checks = 0;
  int slot = -1;
  int irq_cnt, par_cnt, frm_cnt, ovr_cnt;
  int irq_slot, par_slot, frm_slot, ovr_slot;
  int dis_slot = -1;
  int fmt_slot = -1;
  logic [2:0] fmt_new = 3'd0;

  localparam int SLOT_PAR  = 20;
  localparam int SLOT_STOP = 30;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) os_tick <= 1'b0;
    else     os_tick <= ~os_tick;
  end

  uart_rx_timed i_uart_rx_timed (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd), .rx_enable(rx_enable),
    .fmt(fmt), .par_odd(par_odd), .rd_strobe(rd_strobe), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_irq(rx_irq), .par_err_pulse(par_err_pulse),
    .frm_err_pulse(frm_err_pulse), .ovr_err_pulse(ovr_err_pulse),
    .par_err_flag(par_err_flag), .frm_err_flag(frm_err_flag),
    .ovr_err_flag(ovr_err_flag)
  );

  always @(negedge clk) begin
    if (rx_irq)        begin irq_cnt++; irq_slot = slot; end
    if (par_err_pulse) begin par_cnt++; par_slot = slot; end
    if (frm_err_pulse) begin frm_cnt++; frm_slot = slot; end
    if (ovr_err_pulse) begin ovr_cnt++; ovr_slot = slot; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    irq_cnt = 0; par_cnt = 0; frm_cnt = 0; ovr_cnt = 0;
    irq_slot = -1; par_slot = -1; frm_slot = -1; ovr_slot = -1;
  endtask

  task automatic bit_time(input int ticks);
    repeat (2 * ticks) @(negedge clk);
  endtask

  task automatic put_slot(input int s, input logic v);
    slot = s;
    if (s == dis_slot) rx_enable = 1'b0;
    if (s == fmt_slot) fmt = fmt_new;
    rxd = v;
    bit_time(16);
  endtask

  function automatic logic par_of(input logic [8:0] d, input int n, input logic odd);
    logic p = odd;
    for (int i = 0; i < n; i++) p ^= d[i];
    return p;
  endfunction

  task automatic send_frame(input int n, input logic [8:0] d, input logic haspar,
                            input logic pbit, input logic stop_ok);
    put_slot(0, 1'b0);
    for (int i = 0; i < n; i++) put_slot(i + 1, d[i]);
    if (haspar) put_slot(SLOT_PAR, pbit);
    slot = SLOT_STOP;
    if (stop_ok) begin
      rxd = 1'b1; bit_time(16);
    end else begin
      rxd = 1'b0; bit_time(10);
      rxd = 1'b1; bit_time(6);
    end
    slot = -1;
    bit_time(20);
  endtask

  task automatic do_read();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  task automatic t_reset();
    check(rx_data == 9'd0 && !rx_valid && !rx_irq, "R1 data/valid/irq", rx_data, 0);
    check(!par_err_pulse && !frm_err_pulse && !ovr_err_pulse, "R1 pulses",
          {par_err_pulse, frm_err_pulse, ovr_err_pulse}, 0);
    check(!par_err_flag && !frm_err_flag && !ovr_err_flag, "R1 flags",
          {par_err_flag, frm_err_flag, ovr_err_flag}, 0);
  endtask

  task automatic t_formats();
    logic [8:0] pat [5] = '{9'h155, 9'h0AA, 9'h1C3, 9'h13C, 9'h1A6};
    int nb [5] = '{7, 7, 8, 8, 9};
    for (int f = 0; f < 5; f++) begin
      logic [8:0] exp_d;
      logic hp;
      fmt = 3'(f);
      hp = (f == 1) || (f == 3);
      exp_d = pat[f] & ((9'd1 << nb[f]) - 9'd1);
      clear_mon();
      send_frame(nb[f], pat[f], hp, par_of(pat[f], nb[f], 1'b0), 1'b1);
      check(rx_data == exp_d && rx_valid, "R3 data word", rx_data, exp_d);
      check(irq_cnt == 1 && irq_slot == SLOT_STOP, "R4 irq in stop bit", irq_slot, SLOT_STOP);
      check(par_cnt == 0 && frm_cnt == 0 && ovr_cnt == 0, "R5 R6 R7 no error",
            par_cnt + frm_cnt + ovr_cnt, 0);
      do_read();
      check(!rx_valid, "R8 read clears valid", rx_valid, 0);
    end
  endtask

  task automatic t_parity();
    fmt = 3'd3; par_odd = 1'b0; clear_mon();
    send_frame(8, 9'h0B1, 1'b1, ~par_of(9'h0B1, 8, 1'b0), 1'b1);
    check(par_cnt == 1 && par_slot == SLOT_PAR, "R5 even mismatch in parity bit", par_slot, SLOT_PAR);
    check(par_err_flag, "R8 parity sticky set", par_err_flag, 1);
    check(irq_cnt == 1 && rx_data == 9'h0B1, "R5 word still stored", rx_data, 9'h0B1);
    do_read();
    check(!par_err_flag, "R8 parity sticky cleared", par_err_flag, 0);
    fmt = 3'd1; par_odd = 1'b1; clear_mon();
    send_frame(7, 9'h05A, 1'b1, par_of(9'h05A, 7, 1'b1), 1'b1);
    check(par_cnt == 0, "R5 odd match no error", par_cnt, 0);
    do_read(); clear_mon();
    send_frame(7, 9'h05A, 1'b1, ~par_of(9'h05A, 7, 1'b1), 1'b1);
    check(par_cnt == 1 && par_slot == SLOT_PAR, "R5 odd mismatch", par_slot, SLOT_PAR);
    do_read();
    par_odd = 1'b0;
  endtask

  task automatic t_framing();
    fmt = 3'd2; clear_mon();
    send_frame(8, 9'h03C, 1'b0, 1'b0, 1'b0);
    check(frm_cnt == 1 && frm_slot == SLOT_STOP, "R6 framing at stop bit", frm_slot, SLOT_STOP);
    check(irq_cnt == 1 && rx_data == 9'h03C, "R6 word stored", rx_data, 9'h03C);
    check(frm_err_flag, "R8 framing sticky set", frm_err_flag, 1);
    do_read();
    check(!frm_err_flag, "R8 framing sticky cleared", frm_err_flag, 0);
  endtask

  task automatic t_overrun();
    fmt = 3'd2; clear_mon();
    send_frame(8, 9'h011, 1'b0, 1'b0, 1'b1);
    send_frame(8, 9'h0EE, 1'b0, 1'b0, 1'b1);
    check(ovr_cnt == 1 && ovr_slot == SLOT_STOP, "R7 overrun at stop bit", ovr_slot, SLOT_STOP);
    check(rx_data == 9'h011, "R7 unread word kept", rx_data, 9'h011);
    check(ovr_err_flag, "R8 overrun sticky set", ovr_err_flag, 1);
    do_read();
    check(!ovr_err_flag && !rx_valid, "R8 overrun sticky cleared", ovr_err_flag, 0);
  endtask

  task automatic t_glitch();
    clear_mon();
    rxd = 1'b0; bit_time(4);
    rxd = 1'b1; bit_time(40);
    check(irq_cnt == 0 && !rx_valid, "R2 short low rejected", irq_cnt, 0);
    fmt = 3'd2; clear_mon();
    send_frame(8, 9'h069, 1'b0, 1'b0, 1'b1);
    check(irq_cnt == 1 && rx_data == 9'h069, "R2 receiver back to idle", rx_data, 9'h069);
    do_read();
  endtask

  task automatic t_disable();
    fmt = 3'd2; clear_mon(); dis_slot = 3;
    send_frame(8, 9'h0D2, 1'b0, 1'b0, 1'b1);
    dis_slot = -1;
    check(irq_cnt == 1 && rx_data == 9'h0D2, "R9 frame completes after disable", rx_data, 9'h0D2);
    do_read(); clear_mon();
    send_frame(8, 9'h033, 1'b0, 1'b0, 1'b1);
    check(irq_cnt == 0 && !rx_valid, "R9 no frame while disabled", irq_cnt, 0);
    rx_enable = 1'b1;
  endtask

  task automatic t_latch();
    fmt = 3'd2; fmt_new = 3'd0; fmt_slot = 3; clear_mon();
    send_frame(8, 9'h0A5, 1'b0, 1'b0, 1'b1);
    fmt_slot = -1;
    check(rx_data == 9'h0A5 && irq_cnt == 1, "R10 format held for frame", rx_data, 9'h0A5);
    do_read();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_formats();
    t_parity();
    t_framing();
    t_overrun();
    t_glitch();
    t_disable();
    t_latch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule